// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block overlays a 64x64 hardware cursor onto a display pixel stream. A host programs it through a byte-wide register file addressed by a 4-bit offset. Through that file it loads a two-plane cursor bitmap into internal RAM, fills a small colour table, places the cursor and switches it on or off. The bitmap is streamed through a single auto-incrementing data port. The first half of the RAM holds plane p0 and the second half holds plane p1.

On the pixel side, the block receives the raster X/Y coordinate of the current pixel and its background colour. One cycle later it presents either the background or one of three cursor colours. The choice depends on whether the pixel lies inside the cursor square and on the two plane bits stored for that position. The programmed position names the bottom-right pixel of the square, so the cursor spans the 64 columns ending at X and the 64 rows ending at Y.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted the pixel output is 0, the cursor is disabled and all registers are clear. After reset the output equals the background colour sampled one cycle earlier.
- R2: The register offsets are as follows:
  - 0x0: index.
  - 0x4: colour slot select.
  - 0x5: colour data.
  - 0x9: cursor mode.
  - 0xA: indirect data port.
  - 0xB: bitmap data.
  - 0xC and 0xD: X low byte and X high nibble.
  - 0xE and 0xF: Y low byte and Y high nibble.
- R3: The bitmap address is 10 bits. A write to offset 0x0 loads bits 7:0 and keeps bits 9:8. A write to offset 0xA while bits 7:0 equal 0x06 loads bits 9:8 from data bits 3:2, so writing 0x90 clears them.
- R4: Each write to offset 0xB stores the byte at the current address, then adds one to the address. The increment carries from bit 7 into bits 9:8 and wraps from 0x3FF to 0x000.
- R5: Bitmap bytes are laid out as follows:
  - Plane p0 occupies addresses 0 to 511 and plane p1 occupies 512 to 1023.
  - Within a plane, the byte for cursor row r and column c is at r*8 + c/8.
  - Bit 7 of each byte is the leftmost pixel.
- R6: Inside the cursor with the cursor enabled, the code {p1,p0} selects the output:
  - 00 passes the background through.
  - 01 gives cursor colour 0 (slot 1).
  - 10 gives cursor colour 1 (slot 2).
  - 11 gives cursor colour 2 (slot 3).
- R7: A write to offset 0x4 selects colour slot data[1:0] and restarts the byte count. Slot 0 is the overscan colour. Writes to offset 0x5 fill R (bits 23:16), then G (15:8), then B (7:0). After B the slot advances by one, modulo 4.
- R8: Each coordinate is 12 bits. The low byte register sets bits 7:0 and the low nibble of the high register sets bits 11:8. The upper nibble of the high register is ignored.
- R9: The cursor covers columns X-63 to X and rows Y-63 to Y. Cursor column c = px_x-(X-63) and row r = px_y-(Y-63). Pixels outside that square output the background.
- R10: The cursor is enabled only when bits 1:0 of the mode register equal 01; bits 7:2 are ignored. Any other value of bits 1:0 (0x00 among them) disables it, and every pixel then outputs the background.
- R11: pix_out is registered. It reflects px_x, px_y and bg_rgb from exactly one clock edge earlier, with the background delayed by the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and pixel path |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 8 | Register write data |
| px_x | input | 12 | Raster column of the current pixel |
| px_y | input | 12 | Raster row of the current pixel |
| bg_rgb | input | 24 | Background colour {R,G,B} of the current pixel |
| pix_out | output | 24 | Output colour {R,G,B}, one cycle after the inputs |

## Verification
A wrong bitmap address manifests as a shifted or scrambled cursor shape. An address that fails to carry into the upper bits corrupts plane p1 or the lower half of plane p0. Either fault appears on the first frame that passes through the affected rows, one cycle after the pixel is presented. A colour slot counter that goes out of step swaps or blends the three cursor colours. An off-by-one in the window compare shifts the square by one row or column at its edges, which a sweep across the boundary exposes immediately. A mode decode fault leaves the cursor visible after it is switched off, seen on the next pixel inside the square.

// File: rtl/curov_pkg.sv
package curov_pkg;
  localparam int SPAN_LOG2 = 6;
  localparam int SPAN      = 1 << SPAN_LOG2;
  localparam int RAM_AW    = 2 * SPAN_LOG2 - 3 + 1;
  localparam int LO_W      = 8;
  localparam int HI_W      = RAM_AW - LO_W;
  localparam int RGB_W     = 24;
  localparam int SLOTS     = 4;

  typedef enum logic [3:0] {
    RG_INDEX    = 4'h0,
    RG_CLR_ADDR = 4'h4,
    RG_CLR_DATA = 4'h5,
    RG_MODE     = 4'h9,
    RG_PORT     = 4'hA,
    RG_BITMAP   = 4'hB,
    RG_XLO      = 4'hC,
    RG_XHI      = 4'hD,
    RG_YLO      = 4'hE,
    RG_YHI      = 4'hF
  } reg_ofs_e;

  localparam logic [7:0] IND_CTRL_IDX = 8'h06;
  localparam logic [1:0] MODE_3CLR    = 2'b01;

  typedef logic [RGB_W-1:0] rgb_t;

  // Place one colour byte into its R, G or B field.
  function automatic rgb_t put_comp(rgb_t c, logic [1:0] k, logic [7:0] v);
    rgb_t r;
    r = c;
    case (k)
      2'd0:    r[23:16] = v;
      2'd1:    r[15:8]  = v;
      default: r[7:0]   = v;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/curov_regs.sv
module curov_regs
  import curov_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  output logic               ram_we,
  output logic [RAM_AW-1:0]  ram_waddr,
  output logic [7:0]         ram_wdata,
  output rgb_t               palette [SLOTS],
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y,
  output logic               cur_on
);
  localparam int HI_NIB = COORD_W - 8;

  logic [RAM_AW-1:0] ram_addr;
  logic [1:0]        slot;
  logic [1:0]        comp;
  logic [1:0]        mode;

  // Named write events
  logic idx_wr, ind_wr, bmp_wr, mode_wr;
  assign idx_wr  = wr_en && (wr_addr == RG_INDEX);
  assign ind_wr  = wr_en && (wr_addr == RG_PORT) && (ram_addr[LO_W-1:0] == IND_CTRL_IDX);
  assign bmp_wr  = wr_en && (wr_addr == RG_BITMAP);
  assign mode_wr = wr_en && (wr_addr == RG_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr <= '0;
      slot     <= '0;
      comp     <= '0;
      mode     <= '0;
      cur_x    <= '0;
      cur_y    <= '0;
      for (int i = 0; i < SLOTS; i++) palette[i] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RG_INDEX:  ram_addr[LO_W-1:0] <= wr_data;
        RG_PORT:   if (ind_wr) ram_addr[RAM_AW-1:LO_W] <= wr_data[3:2];
        RG_BITMAP: ram_addr <= ram_addr + 1'b1;
        RG_CLR_ADDR: begin
          slot <= wr_data[1:0];
          comp <= 2'd0;
        end
        RG_CLR_DATA: begin
          palette[slot] <= put_comp(palette[slot], comp, wr_data);
          if (comp == 2'd2) begin
            comp <= 2'd0;
            slot <= slot + 1'b1;
          end else begin
            comp <= comp + 1'b1;
          end
        end
        RG_MODE: mode <= wr_data[1:0];
        RG_XLO:  cur_x[7:0] <= wr_data;
        RG_XHI:  cur_x[COORD_W-1:8] <= wr_data[HI_NIB-1:0];
        RG_YLO:  cur_y[7:0] <= wr_data;
        RG_YHI:  cur_y[COORD_W-1:8] <= wr_data[HI_NIB-1:0];
        default: ;
      endcase
    end
  end

  assign ram_we    = bmp_wr;
  assign ram_waddr = ram_addr;
  assign ram_wdata = wr_data;
  assign cur_on    = (mode == MODE_3CLR);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bmp_wr |=> ram_addr == RAM_AW'($past(ram_addr) + 1'b1));

  p_index_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (ram_addr[LO_W-1:0] == $past(wr_data)) &&
               (ram_addr[RAM_AW-1:LO_W] == $past(ram_addr[RAM_AW-1:LO_W])));

  p_upper_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ind_wr |=> (ram_addr[RAM_AW-1:LO_W] == $past(wr_data[3:2])) &&
               (ram_addr[LO_W-1:0] == $past(ram_addr[LO_W-1:0])));

  p_comp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    comp != 2'd3);

  p_mode_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wr_data[1:0] != MODE_3CLR) |=> !cur_on);
endmodule

// File: rtl/curov_ram.sv
module curov_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-2:0] raddr,
  output logic [7:0]    rd_lo,
  output logic [7:0]    rd_hi
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Both planes are read at the same in-plane offset.
  assign rd_lo = mem[{1'b0, raddr}];
  assign rd_hi = mem[{1'b1, raddr}];
endmodule

// File: rtl/curov_pixel.sv
module curov_pixel
  import curov_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  rgb_t               bg,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic               cur_on,
  input  rgb_t               palette [SLOTS],
  output logic [RAM_AW-2:0]  rd_addr,
  input  logic [7:0]         rd_p0,
  input  logic [7:0]         rd_p1,
  output rgb_t               pix_out
);
  // {inside, offset}: offset counts from the far (top/left) edge of the square.
  function automatic logic [SPAN_LOG2:0] axis_probe(logic [COORD_W-1:0] corner,
                                                    logic [COORD_W-1:0] pos);
    logic [COORD_W:0] d;
    d = {1'b0, corner} - {1'b0, pos};
    return {(!d[COORD_W] && (d[COORD_W-1:0] < COORD_W'(SPAN))), ~d[SPAN_LOG2-1:0]};
  endfunction

  logic [SPAN_LOG2:0]   hx, hy;
  logic                 win;
  logic [SPAN_LOG2-1:0] col, row;
  logic [2:0]           bsel;
  logic [1:0]           code;

  assign hx      = axis_probe(cur_x, px_x);
  assign hy      = axis_probe(cur_y, px_y);
  assign win     = hx[SPAN_LOG2] && hy[SPAN_LOG2];
  assign col     = hx[SPAN_LOG2-1:0];
  assign row     = hy[SPAN_LOG2-1:0];
  assign rd_addr = {row, col[SPAN_LOG2-1:3]};
  assign bsel    = ~col[2:0];
  assign code    = {rd_p1[bsel], rd_p0[bsel]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pix_out <= '0;
    else if (cur_on && win && code != 2'b00) pix_out <= palette[code];
    else                                  pix_out <= bg;
  end

  p_off_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_on |=> pix_out == $past(bg));

  p_miss_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> pix_out == $past(bg));

  p_clear_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win && code == 2'b00) |=> pix_out == $past(bg));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import curov_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [RGB_W-1:0]   bg_rgb,
  output logic [RGB_W-1:0]   pix_out
);
  logic               ram_we;
  logic [RAM_AW-1:0]  ram_waddr;
  logic [7:0]         ram_wdata;
  rgb_t               palette [SLOTS];
  logic [COORD_W-1:0] cur_x, cur_y;
  logic               cur_on;
  logic [RAM_AW-2:0]  rd_addr;
  logic [7:0]         rd_p0, rd_p1;

  curov_regs #(.COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .palette(palette), .cur_x(cur_x), .cur_y(cur_y), .cur_on(cur_on)
  );

  curov_ram #(.AW(RAM_AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rd_lo(rd_p0), .rd_hi(rd_p1)
  );

  curov_pixel #(.COORD_W(COORD_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .px_x(px_x), .px_y(px_y), .bg(bg_rgb),
    .cur_x(cur_x), .cur_y(cur_y), .cur_on(cur_on), .palette(palette),
    .rd_addr(rd_addr), .rd_p0(rd_p0), .rd_p1(rd_p1), .pix_out(pix_out)
  );
endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] px_x = '0;
  logic [11:0] px_y = '0;
  logic [23:0] bg_rgb = 24'h0;
  logic [23:0] pix_out;

  int  total = 0;
  int  fails = 0;
  bit  done  = 0;

  // Bench model of the programmed state
  logic [7:0]  bm [1024];
  logic [23:0] pal [4];
  int maddr = 0, slot = 0, comp = 0, cx = 0, cy = 0;
  bit on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .px_x(px_x), .px_y(px_y), .bg_rgb(bg_rgb), .pix_out(pix_out)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 73 + (a >> 3) * 29 + 5) & 255);
  endfunction

  // Expected pixel from R5, R6, R9, R10
  function automatic logic [23:0] exp_pix(int x, int y, logic [23:0] bg);
    int dx, dy, c, r, a, b, code;
    dx = cx - x;
    dy = cy - y;
    if (!on || dx < 0 || dx > 63 || dy < 0 || dy > 63) return bg;
    c = 63 - dx;
    r = 63 - dy;
    a = r * 8 + c / 8;
    b = 7 - (c % 8);
    code = 2 * int'(bm[512 + a][b]) + int'(bm[a][b]);
    return (code == 0) ? bg : pal[code];
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One register write; caller is at a falling edge. Model per R2-R4, R7, R8, R10.
  task automatic reg_wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      4'h0: maddr = (maddr & 'h300) | int'(d);
      4'hA: if ((maddr & 'hFF) == 6) maddr = (maddr & 'hFF) | ((int'(d) >> 2 & 3) << 8);
      4'hB: begin bm[maddr] = d; maddr = (maddr + 1) % 1024; end
      4'h4: begin slot = int'(d) % 4; comp = 0; end
      4'h5: begin
        pal[slot][23 - 8 * comp -: 8] = d;
        comp++;
        if (comp == 3) begin comp = 0; slot = (slot + 1) % 4; end
      end
      4'h9: on = (d[1:0] == 2'b01);
      4'hC: cx = (cx & 'hF00) | int'(d);
      4'hD: cx = (cx & 'hFF) | ((int'(d) & 'hF) << 8);
      4'hE: cy = (cy & 'hF00) | int'(d);
      4'hF: cy = (cy & 'hFF) | ((int'(d) & 'hF) << 8);
      default: ;
    endcase
  endtask

  task automatic place(int x, int y, logic [7:0] junk);
    reg_wr(4'hC, 8'(x & 255));
    reg_wr(4'hD, 8'((x >> 8) & 15) | junk);
    reg_wr(4'hE, 8'(y & 255));
    reg_wr(4'hF, 8'((y >> 8) & 15) | junk);
  endtask

  // Drive one pixel and sample one cycle later (R11)
  task automatic probe(int x, int y, string req);
    logic [23:0] bgv, e;
    bgv = 24'($urandom);
    px_x = 12'(x); px_y = 12'(y); bg_rgb = bgv;
    e = exp_pix(x & 'hFFF, y & 'hFFF, bgv);
    @(negedge clk);
    check(req, pix_out, e);
  endtask

  task automatic sweep(int x0, int x1, int y0, int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        probe(x, y, "R5/R6/R9/R11 sweep");
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    for (int i = 0; i < 4; i++) pal[i] = '0;
    for (int i = 0; i < 1024; i++) bm[i] = '0;
    bg_rgb = 24'h123456;
    repeat (3) @(negedge clk);
    check("R1 reset output", pix_out, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bg_rgb = 24'hA5C3E1;
    @(negedge clk);
    check("R1 background after reset", pix_out, 24'hA5C3E1);
    probe(0, 0, "R1/R10 disabled at reset");

    // R7: colours from slot 0, three bytes each
    reg_wr(4'h4, 8'h00);
    for (int i = 0; i < 12; i++) reg_wr(4'h5, 8'(i * 21 + 7));
    // R3: clear upper address bits via indirect register, then index 0
    reg_wr(4'h0, 8'h06);
    reg_wr(4'hA, 8'h90);
    reg_wr(4'h0, 8'h00);
    // R4/R5: stream both planes, relying on carry into the upper bits
    for (int i = 0; i < 1024; i++) reg_wr(4'hB, pat(i));

    // R8: junk in the upper nibble of the high registers is ignored
    place(40, 30, 8'hF0);
    reg_wr(4'h9, 8'h01);
    sweep(0, 100, 0, 70);

    // R3: upper bits 01, index 0x10 -> address 0x110
    reg_wr(4'h0, 8'h06);
    reg_wr(4'hA, 8'h94);
    reg_wr(4'h0, 8'h10);
    reg_wr(4'hB, 8'hA5);
    reg_wr(4'hB, 8'h3C);
    // R4: carry from 0x2FF into 0x300
    reg_wr(4'h0, 8'h06);
    reg_wr(4'hA, 8'h98);
    reg_wr(4'h0, 8'hFF);
    reg_wr(4'hB, 8'hF0);
    reg_wr(4'hB, 8'h0F);
    // R7: rewrite cursor colour 1 only
    reg_wr(4'h4, 8'h02);
    reg_wr(4'h5, 8'hDE);
    reg_wr(4'h5, 8'hAD);
    reg_wr(4'h5, 8'h99);
    place('h123, 'h0C8, 8'h00);
    sweep('h123 - 70, 'h123 + 4, 'h0C8 - 70, 'h0C8 + 4);

    // R10: mode decode
    reg_wr(4'h9, 8'h02);
    for (int i = 0; i < 60; i++)
      probe('h123 - int'($urandom_range(63)), 'h0C8 - int'($urandom_range(63)), "R10 mode 2 off");
    reg_wr(4'h9, 8'h81);
    for (int i = 0; i < 60; i++)
      probe('h123 - int'($urandom_range(63)), 'h0C8 - int'($urandom_range(63)), "R10 upper bits ignored");
    reg_wr(4'h9, 8'h00);
    for (int i = 0; i < 60; i++)
      probe('h123 - int'($urandom_range(63)), 'h0C8 - int'($urandom_range(63)), "R10 off");
    reg_wr(4'h9, 8'h01);

    // Random placements including screen edges (R9)
    for (int k = 0; k < 8; k++) begin
      int px, py;
      px = (k == 0) ? 0 : (k == 1) ? 4095 : int'($urandom_range(4095));
      py = (k == 2) ? 0 : (k == 3) ? 4095 : int'($urandom_range(4095));
      place(px, py, 8'(int'($urandom_range(15)) << 4));
      for (int i = 0; i < 400; i++)
        probe((px - 70 + int'($urandom_range(76))) & 'hFFF,
              (py - 70 + int'($urandom_range(76))) & 'hFFF, "R6/R9 random");
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule